// File: doc/BRIEF.md
# Mask-Write GPIO Data Bank

This block is one 32-pin general-purpose I/O bank behind a small 32-bit register bus. Software can change any group of output bits with a single store. Two half-word update registers each carry a per-pin write mask in their upper 16 bits and new pin values in their lower 16 bits. A mask bit of 0 lets the matching data bit through to the output latch, and a mask bit of 1 keeps the latched bit as it is. No read-modify-write is needed.

The bank also holds a direction register and an output-enable register, both read/write. A read-only register returns the pin levels after they pass through a synchroniser. The pad side has three separate vectors: output values, output enables and input levels. The index parameter `BANK_IDX` moves every register address by a fixed stride per bank. In bank 0, pins 7 and 8 are fixed as outputs.

Top module: `gpio_mask_bank`

## Requirements
- R1: A write to the low update register (byte address 0x000 + 8*BANK_IDX) updates `pin_out[15:0]`: each bit i whose mask bit `wdata[16+i]` is 0 takes the value `wdata[i]`. The new value is visible after the clock edge that accepts the write.
- R2: A write to the high update register (0x004 + 8*BANK_IDX) applies the same masked update to `pin_out[31:16]`. Mask bits are in `wdata[31:16]` and data bits are in `wdata[15:0]`.
- R3: Any output bit whose mask bit is 1 in an update write keeps its previous value.
- R4: Both update registers are write-only and read as zero. Any address that is not decoded reads as zero, and writing to it changes no output and no register.
- R5: The direction register (0x204 + 0x40*BANK_IDX) is read/write. A bit value of 1 makes the pin an output and 0 makes it an input.
- R6: The output-enable register (0x208 + 0x40*BANK_IDX) is read/write.
- R7: `pin_oe[i]` is 1 only when direction bit i and output-enable bit i are both 1.
- R8: The level register (0x060 + 4*BANK_IDX) returns `pin_in` through a two-flop synchroniser. A change on `pin_in` first appears in a read accepted on the third clock edge after the change. Writes to this register are ignored.
- R9: In bank 0, direction bits 7 and 8 always read as 1, and a write cannot clear them.
- R10: After reset, the output latch and the output-enable register are zero. The direction register is zero except for the bits fixed by R9.
- R11: `rdata` is registered. It carries the value of the register read in the cycle after `rd_en`, and it is zero after any cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (10) | Byte address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| pin_in | input | DATA_W (32) | Pin input levels |
| pin_out | output | DATA_W (32) | Output latch value per pin |
| pin_oe | output | DATA_W (32) | Per-pin output enable |

## Verification
Writes take effect at the clock edge that accepts them. The bench drives each write at a falling edge and compares `pin_out` and `pin_oe` at the next falling edge, after one rising edge. Read data is due one edge after `rd_en`, and the bench samples it at the following falling edge. `rdata` returns to zero one edge later, and the bench checks for that too. A change on `pin_in` needs two synchroniser edges plus the read edge before it can be seen. The bench therefore issues three back-to-back reads and expects the old level on the first two and the new level on the third.

// File: rtl/gpio_mask_bank_pkg.sv
package gpio_mask_bank_pkg;
   // address plan: update registers and level register step per bank
   localparam int unsigned UPD_BASE  = 32'h000;
   localparam int unsigned UPD_STEP  = 8;
   localparam int unsigned LVL_BASE  = 32'h060;
   localparam int unsigned LVL_STEP  = 4;
   localparam int unsigned CFG_BASE  = 32'h204;
   localparam int unsigned CFG_STEP  = 32'h40;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_UPD_LO,
      SEL_UPD_HI,
      SEL_LEVEL,
      SEL_DIR,
      SEL_OEN
   } reg_sel_e;
endpackage

// File: rtl/gmb_decode.sv
module gmb_decode
   import gpio_mask_bank_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned BANK_IDX = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(UPD_BASE + UPD_STEP * BANK_IDX);
   localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(UPD_BASE + UPD_STEP * BANK_IDX + 4);
   localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(LVL_BASE + LVL_STEP * BANK_IDX);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(CFG_BASE + CFG_STEP * BANK_IDX);
   localparam logic [ADDR_W-1:0] A_OEN = ADDR_W'(CFG_BASE + CFG_STEP * BANK_IDX + 4);

   if ((CFG_BASE + CFG_STEP * BANK_IDX + 4) >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("gmb_decode: ADDR_W too narrow for BANK_IDX");
   end

   always_comb begin
      if (addr == A_LO)       sel = SEL_UPD_LO;
      else if (addr == A_HI)  sel = SEL_UPD_HI;
      else if (addr == A_LVL) sel = SEL_LEVEL;
      else if (addr == A_DIR) sel = SEL_DIR;
      else if (addr == A_OEN) sel = SEL_OEN;
      else                    sel = SEL_NONE;
   end
endmodule

// File: rtl/gmb_sync.sv
module gmb_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gmb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= d;
         else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gmb_regs.sv
module gmb_regs
   import gpio_mask_bank_pkg::*;
#(
   parameter int unsigned       DATA_W = 32,
   parameter logic [DATA_W-1:0] FIXED_OUT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dir_q,
   output logic [DATA_W-1:0] oen_q,
   output logic [DATA_W-1:0] lat_q
);
   localparam int unsigned HALF = DATA_W / 2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= FIXED_OUT;
         oen_q <= '0;
      end else if (we) begin
         if (sel == SEL_DIR) dir_q <= wdata | FIXED_OUT;
         if (sel == SEL_OEN) oen_q <= wdata;
      end
   end

   // one masked-update lane per half of the bank
   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam reg_sel_e MY_SEL = (h == 0) ? SEL_UPD_LO : SEL_UPD_HI;
      logic [HALF-1:0] keep;
      logic [HALF-1:0] fresh;
      assign keep  = wdata[DATA_W-1:HALF];
      assign fresh = wdata[HALF-1:0];

      always_ff @(posedge clk) begin
         if (!rst_n)
            lat_q[h*HALF +: HALF] <= '0;
         else if (we && sel == MY_SEL)
            lat_q[h*HALF +: HALF] <= (lat_q[h*HALF +: HALF] & keep) | (fresh & ~keep);
      end
   end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
   import gpio_mask_bank_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned BANK_IDX    = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe
);
   localparam logic [DATA_W-1:0] FIXED_OUT =
      (BANK_IDX == 0) ? DATA_W'(32'h0000_0180) : '0;

   if (DATA_W != 32) begin : g_bad_width
      $error("gpio_mask_bank: DATA_W must be 32 (16-bit mask plus 16-bit data)");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] dir_q;
   logic [DATA_W-1:0] oen_q;
   logic [DATA_W-1:0] lat_q;
   logic [DATA_W-1:0] lvl_q;

   gmb_decode #(.ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_decode (
      .addr (addr),
      .sel  (sel)
   );

   gmb_regs #(.DATA_W(DATA_W), .FIXED_OUT(FIXED_OUT)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .sel   (sel),
      .wdata (wdata),
      .dir_q (dir_q),
      .oen_q (oen_q),
      .lat_q (lat_q)
   );

   gmb_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !rd_en) begin
         rdata <= '0;
      end else begin
         unique case (sel)
            SEL_LEVEL: rdata <= lvl_q;
            SEL_DIR:   rdata <= dir_q;
            SEL_OEN:   rdata <= oen_q;
            default:   rdata <= '0;
         endcase
      end
   end

   assign pin_out = lat_q;
   assign pin_oe  = dir_q & oen_q;
endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned BANK_IDX = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] pin_out,
   input logic [DATA_W-1:0] pin_oe,
   input logic [DATA_W-1:0] dir_q
);
   localparam int unsigned HALF = DATA_W / 2;
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(8 * BANK_IDX);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(8 * BANK_IDX + 4);
   localparam logic [DATA_W-1:0] PINNED = (BANK_IDX == 0) ? DATA_W'(32'h180) : '0;

   logic upd_lo, upd_hi;
   assign upd_lo = wr_en && addr == LO_A;
   assign upd_hi = wr_en && addr == HI_A;

   // R1
   lo_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_lo |=> ((pin_out[HALF-1:0] ^ $past(wdata[HALF-1:0])) & ~$past(wdata[DATA_W-1:HALF])) == '0);

   // R3
   masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_hi |=> ((pin_out[DATA_W-1:HALF] ^ $past(pin_out[DATA_W-1:HALF])) & $past(wdata[DATA_W-1:HALF])) == '0);

   // R4
   no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_lo || upd_hi) |=> $stable(pin_out));

   // R4
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == LO_A || addr == HI_A)) |=> rdata == '0);

   // R7
   oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~dir_q) == '0);

   // R9
   pinned_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q & PINNED) == PINNED);

   // R11
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> rdata == '0);
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe), .dir_q(dir_q)
);

// File: tb/gpio_mask_bank_tb.sv
`timescale 1ns/1ps
module gpio_mask_bank_tb;
   localparam logic [9:0] A_LO  = 10'h000;
   localparam logic [9:0] A_HI  = 10'h004;
   localparam logic [9:0] A_LVL = 10'h060;
   localparam logic [9:0] A_DIR = 10'h204;
   localparam logic [9:0] A_OEN = 10'h208;
   localparam logic [31:0] PIN78 = 32'h0000_0180;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;

   int vectors = 0;
   int miscompares = 0;
   logic [31:0] m_lat = '0, m_dir = PIN78, m_oen = '0;

   always #2 clk = ~clk;

   gpio_mask_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   function automatic logic [15:0] masked(input logic [15:0] old, input logic [31:0] w);
      return (old & w[31:16]) | (w[15:0] & ~w[31:16]);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == A_LO)  m_lat[15:0]  = masked(m_lat[15:0], d);
      if (a == A_HI)  m_lat[31:16] = masked(m_lat[31:16], d);
      if (a == A_DIR) m_dir = d | PIN78;
      if (a == A_OEN) m_oen = d;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic check_pins(input string req);
      check({req, " pin_out"}, pin_out, m_lat);
      check({req, " pin_oe"}, pin_oe, m_dir & m_oen);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state, R9 pinned direction bits
      check_pins("R10");
      rd(A_DIR, r); check("R10 R9 dir reset", r, PIN78);
      rd(A_OEN, r); check("R10 oe reset", r, 32'h0);

      // R1 all-open mask on low half
      wr(A_LO, 32'h0000_A5A5); check("R1 low update", pin_out, 32'h0000_A5A5);
      // R2 high half
      wr(A_HI, 32'h0000_1234); check("R2 high update", pin_out, 32'h1234_A5A5);
      // R3 partial mask keeps upper byte of low half
      wr(A_LO, 32'hFF00_00FF); check("R3 masked keep", pin_out, 32'h1234_A5FF);
      wr(A_HI, 32'hFFFF_0000); check("R3 full mask", pin_out, 32'h1234_A5FF);

      // R4 write-only registers read zero, unmapped write ignored
      rd(A_LO, r); check("R4 low reads zero", r, 32'h0);
      rd(A_HI, r); check("R4 high reads zero", r, 32'h0);
      wr(10'h100, 32'hFFFF_FFFF); check_pins("R4 unmapped write");
      rd(A_DIR, r); check("R4 dir untouched", r, PIN78);
      rd(10'h100, r); check("R4 unmapped read", r, 32'h0);

      // R9 attempt to clear pinned bits
      wr(A_DIR, 32'h0); rd(A_DIR, r); check("R9 pinned dir", r, PIN78);

      // R5 R6 R7
      wr(A_DIR, 32'hFFFF_0000); rd(A_DIR, r); check("R5 dir rw", r, 32'hFFFF_0180);
      wr(A_OEN, 32'h0F0F_0F0F); rd(A_OEN, r); check("R6 oe rw", r, 32'h0F0F_0F0F);
      check("R7 pin_oe", pin_oe, 32'h0F0F_0100);

      // R8 synchroniser latency: old, old, new
      pin_in = 32'hDEAD_BEEF;
      rd(A_LVL, r); check("R8 lvl edge1", r, 32'h0);
      rd(A_LVL, r); check("R8 lvl edge2", r, 32'h0);
      rd(A_LVL, r); check("R8 lvl edge3", r, 32'hDEAD_BEEF);
      wr(A_LVL, 32'h1234_5678); check_pins("R8 lvl write");
      rd(A_LVL, r); check("R8 lvl read-only", r, 32'hDEAD_BEEF);

      // R11 rdata returns to zero without rd_en
      rd(A_DIR, r);
      @(negedge clk); check("R11 idle rdata", rdata, 32'h0);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned k;
         logic [31:0] d;
         k = $urandom_range(0, 8);
         d = $urandom();
         if (k == 2) d[31:16] = 16'h0;
         case (k)
            0, 2: begin wr(A_LO, d); check_pins("R1 R3 random"); end
            1:    begin wr(A_HI, d); check_pins("R2 R3 random"); end
            3:    begin wr(A_DIR, d); check_pins("R5 R7 random"); end
            4:    begin wr(A_OEN, d); check_pins("R6 R7 random"); end
            5:    begin rd(A_DIR, r); check("R5 R9 random read", r, m_dir); end
            6:    begin rd(A_OEN, r); check("R6 random read", r, m_oen); end
            7:    begin rd(A_LVL, r); check("R8 random read", r, pin_in); end
            default: begin
               wr(10'(($urandom_range(0, 60)) * 16 + 12), d); check_pins("R4 random stray");
            end
         endcase
         if (i % 50 == 49) begin
            pin_in = $urandom();
            repeat (3) @(negedge clk);
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule